// File: doc/BRIEF.md
# Carry-Save Sequential Multiplier

This block multiplies two unsigned `WIDTH`-bit operands into a `2*WIDTH`-bit product, one multiplier bit per clock, starting from the least significant bit. The running partial product is kept as two vectors, a sum and a carry, so an iteration costs one layer of full adders and no carry ripple. Each iteration adds the multiplicand when the current multiplier bit is 1 and zero when it is 0. The result then shifts right by one place. The bit that drops out at the bottom joins the low half of the product. That bit is exact, because the carry vector stays aligned one place above the sum vector.

When all multiplier bits have been consumed, one carry-propagate add resolves the high half. That add is given two whole clock cycles: its inputs are frozen for both, and the product register loads only on the second. A one-cycle pulse on `start_i` launches an operation, and a one-cycle pulse on `done_o` marks a fresh product. A start pulse that arrives while an operation is running is dropped.

Top module: `mul_csa_seq`

## Requirements
- R1: After `done_o` pulses, `product_o` equals the unsigned product of the `mcand_i` and `mplr_i` values that were sampled with the accepted start, including zero and all-ones operands.
- R2: If `start_i` is sampled high at clock edge t while idle, `done_o` is high from edge t+WIDTH+2 to edge t+WIDTH+3. That is WIDTH carry-save iterations plus a two-cycle resolve.
- R3: `done_o` is high for exactly one cycle per operation.
- R4: A start request sampled while an operation is in progress is ignored. The running operation keeps its result and its timing.
- R5: `product_o` holds the previous result from the accepted start until the next completion.
- R6: While reset is active, and just after it, `done_o` is 0 and `product_o` is 0.
- R7: The product register does not load on the first resolve cycle, the edge t+WIDTH+1. The sum and carry vectors stay frozen through both resolve cycles.
- R8: Changes on `mcand_i` and `mplr_i` after the start edge have no effect on the result.
- R9: During iteration the step counter falls by one per cycle, and the resolve begins after exactly WIDTH iterations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, honoured only when idle |
| mcand_i | input | WIDTH | Multiplicand, sampled on the accepted start |
| mplr_i | input | WIDTH | Multiplier, sampled on the accepted start |
| done_o | output | 1 | One-cycle pulse marking a new product |
| product_o | output | 2*WIDTH | Registered unsigned product |

## Verification
The assertions take for granted that reset is applied before the first start and that `start_i` never carries an unknown value. They check the control sequence and the freezing of the datapath, and nothing about operand values. The stimulus changes `start_i` and the operands only at falling clock edges. It deliberately holds `start_i` high and scrambles the operands for most of each operation, and drops both before the block returns to idle. This keeps every accepted start intentional and separate from the rejected ones.

// File: rtl/mul_csa_pkg.sv
package mul_csa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ITER  = 3'd1,
    ST_RES1  = 3'd2,
    ST_RES2  = 3'd3,
    ST_DONE  = 3'd4
  } mul_state_e;
endpackage

// File: rtl/mul_csa_row.sv
module mul_csa_row #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic [WIDTH-1:0] z_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] cry_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_fa
    assign sum_o[g] = x_i[g] ^ y_i[g] ^ z_i[g];
    assign cry_o[g] = (x_i[g] & y_i[g]) | (x_i[g] & z_i[g]) | (y_i[g] & z_i[g]);
  end
endmodule

// File: rtl/mul_csa_ctrl.sv
module mul_csa_ctrl
  import mul_csa_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic cap_o,
  output logic done_o,
  output logic busy_o
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  mul_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_ITER;
      ST_ITER: if (cnt_q == '0) state_d = ST_RES1;
      ST_RES1: state_d = ST_RES2;
      ST_RES2: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load_o) cnt_q <= LAST;
      else if (step_o && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_ITER);
  assign cap_o  = (state_q == ST_RES2);  // second resolve cycle only
  assign done_o = (state_q == ST_DONE);

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && cnt_q != '0) |=> (step_o && cnt_q == $past(cnt_q) - 1'b1));
  // R9
  iter_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && cnt_q == '0) |=> (state_q == ST_RES1));
  // R4
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |-> !load_o);
endmodule

// File: rtl/mul_csa_dp.sv
module mul_csa_dp #(
  parameter int WIDTH = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic               cap_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplr_i,
  output logic [2*WIDTH-1:0] product_o
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q, mplr_q, sum_q, cry_q;
  logic [WIDTH-1:0] addend, sum_v, cry_v, hi_w;
  logic [PW-1:0]    product_q;

  assign addend = mplr_q[0] ? mcand_q : '0;

  mul_csa_row #(.WIDTH(WIDTH)) u_row (
    .x_i  (sum_q),
    .y_i  (cry_q),
    .z_i  (addend),
    .sum_o(sum_v),
    .cry_o(cry_v)
  );

  // carry vector sits one place above sum, so sum_v[0] is an exact product bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      mplr_q  <= '0;
      sum_q   <= '0;
      cry_q   <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      mplr_q  <= mplr_i;
      sum_q   <= '0;
      cry_q   <= '0;
    end else if (step_i) begin
      sum_q   <= {1'b0, sum_v[WIDTH-1:1]};
      cry_q   <= cry_v;
      mplr_q  <= {sum_v[0], mplr_q[WIDTH-1:1]};
    end
  end

  // two-cycle path: sum_q/cry_q frozen through both resolve cycles
  assign hi_w = sum_q + cry_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    product_q <= '0;
    else if (cap_i) product_q <= {hi_w, mplr_q};
  end

  assign product_o = product_q;

  // R5
  prod_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(product_q));
  // R7
  resolve_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> ($stable(sum_q) && $stable(cry_q)));
  // R8
  mcand_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(mcand_q));
endmodule

// File: rtl/mul_csa_seq.sv
module mul_csa_seq #(
  parameter int WIDTH = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplr_i,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  logic load, step, cap, busy;

  mul_csa_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .cap_o  (cap),
    .done_o (done_o),
    .busy_o (busy)
  );

  mul_csa_dp #(.WIDTH(WIDTH)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (step),
    .cap_i    (cap),
    .mcand_i  (mcand_i),
    .mplr_i   (mplr_i),
    .product_o(product_o)
  );

  // R7
  cap_after_res1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |-> ($past(busy) && !$past(step) && !$past(cap)));
  // R2
  done_after_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(cap));
endmodule

// File: tb/sim_mul_csa_seq.sv
module sim_mul_csa_seq;
  localparam int W = 64;
  localparam int PW = 2 * W;
  localparam time CLK_PERIOD = 10ns;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [W-1:0]  mcand_i = '0;
  logic [W-1:0]  mplr_i = '0;
  logic          done_o;
  logic [PW-1:0] product_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  mul_csa_seq #(.WIDTH(W)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .mcand_i(mcand_i), .mplr_i(mplr_i),
    .done_o(done_o), .product_o(product_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [PW-1:0] acc = '0;
    for (int i = 0; i < W; i++)
      if (b[i]) acc = acc + ({{W{1'b0}}, a} << i);
    return acc;
  endfunction

  function automatic logic [W-1:0] rnd_word();
    return {$urandom(), $urandom()};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [PW-1:0] act,
                     input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
    logic [PW-1:0] exp, prev;
    int n;
    bit held, res1_ok;
    exp = ref_mul(a, b);
    @(negedge clk_i);
    prev = product_o;
    mcand_i = a; mplr_i = b; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    n = 0; held = 1'b1; res1_ok = 1'b1;
    while (!done_o && n < W + 8) begin
      if (product_o !== prev) held = 1'b0;
      if (n == W + 1 && product_o !== prev) res1_ok = 1'b0;
      if (poke) begin
        start_i = (n < W);
        mcand_i = rnd_word(); mplr_i = rnd_word();
      end
      @(negedge clk_i);
      n++;
    end
    start_i = 1'b0;
    chk(n == W + 2, "R2 latency", PW'(n), PW'(W + 2));
    chk(product_o === exp, poke ? "R1/R4/R8 product under busy start" : "R1 product",
        product_o, exp);
    chk(held, "R5 hold during op", product_o, prev);
    chk(res1_ok, "R7 no load on first resolve", product_o, prev);
    @(negedge clk_i);
    chk(done_o === 1'b0, "R3 done one cycle", PW'(done_o), '0);
    chk(product_o === exp, "R5 hold after done", product_o, exp);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk(done_o === 1'b0, "R6 reset done", PW'(done_o), '0);
    chk(product_o === '0, "R6 reset product", product_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(done_o === 1'b0 && product_o === '0, "R6 after reset", product_o, '0);
    run_op('0, '0, 1'b0);
    run_op('1, '1, 1'b0);
    run_op('1, '0, 1'b0);
    run_op('0, '1, 1'b0);
    run_op(W'(1), '1, 1'b0);
    run_op({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, 1'b0);
    run_op('1, '1, 1'b1);
    for (int i = 0; i < 24; i++) run_op(rnd_word(), rnd_word(), (i % 3) == 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule